// File: doc/BRIEF.md
# Banked Windowed Register File

This block is a register file that puts three kinds of storage behind one 7-bit register specifier. There is a small group of static registers that are always visible. There is a windowed stack in which every procedure frame sees an incoming, a local and an outgoing group of sixteen registers. There is a short group of scratchpad registers that only privileged code may touch. A call slides the window so that the caller's outgoing group becomes the callee's incoming group, and a return slides it back. Moving arguments between frames therefore costs no copying.

The windowed stack is held several times over, once per bank. Each bank keeps its own window pointer and depth. A process switch only changes the bank select, and nothing is saved or restored. The highest bank belongs to the kernel. Raising the privilege input switches to it at once and leaves the process banks untouched. Spilling frames to memory is left to the surroundings. The block only reports a call that would run past the last frame, or a return from the base frame. Reads are combinational. The single write port commits on the clock edge, and it is forwarded to a read of the same location in the same cycle.

Top module: `rwf_banked_regfile`

## Requirements
- R1: Specifiers 0 to 15 address the static registers. These are the same storage whatever the bank, the window depth or the privilege.
- R2: Specifiers 16–31 are the incoming group, 32–47 the local group and 48–63 the outgoing group of the current window. After a call, outgoing register 48+n of the caller reads as incoming register 16+n. A return brings back the caller's local and outgoing contents.
- R3: Each bank has 4 frames. A call made at depth 3 does not move the window. It drives overflow_o high for exactly the cycle after the call edge.
- R4: A return made at the base frame (depth 0) does not move the window. It drives underflow_o high for exactly the cycle after the return edge.
- R5: If call_i and ret_i are both high in one cycle, the window does not move and no flag is raised.
- R6: bank_sel_i is taken up at the next clock edge. Each bank has its own stack contents and its own window depth, and a call or return acts only on the active bank.
- R7: While kernel_i is high, the kernel bank (bank NBANK-1) is active at once, whatever the selected bank. A bank_sel_i value equal to the kernel bank is ignored, and the selected bank is kept.
- R8: Specifiers 64–71 address 8 scratchpad registers. They are read and written normally while kernel_i is high. Without privilege a read returns 0, a write is dropped, and priv_fault_o goes high in the next cycle.
- R9: Specifiers 72–127 are reserved. A read returns 0 and a write changes no register.
- R10: A read of the location being written in the same cycle returns the new write data.
- R11: After reset all flags are low, bank 0 is selected and every bank's window is at its base frame.
- R12: A write made in the same cycle as a call goes to the window that was current before the call.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| kernel_i | input | 1 | Privilege; selects the kernel bank and opens the scratchpad |
| bank_sel_i | input | 2 | Process bank to use from the next edge |
| call_i | input | 1 | Slide the active window one frame deeper |
| ret_i | input | 1 | Slide the active window one frame back |
| rd_a_spec_i | input | 7 | Read port A specifier |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_spec_i | input | 7 | Read port B specifier |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | Write enable |
| wr_spec_i | input | 7 | Write specifier |
| wr_data_i | input | 32 | Write data |
| overflow_o | output | 1 | Call refused because all frames are in use |
| underflow_o | output | 1 | Return refused at the base frame |
| priv_fault_o | output | 1 | Unprivileged scratchpad access in the previous cycle |

## Verification
Two pairs of functions can meet in one cycle: a write with a call, and a write with a read of the same location. For the first, the bench drives an outgoing-register write and call_i in one cycle. It then expects that value to read back through the matching incoming specifier of the new frame, which shows the write landed in the caller's window. For the second, the bench holds a read specifier equal to the write specifier, for both a static and a windowed location. It compares the combinational read data with the write data before the clock edge, and again after the edge to confirm the stored value.

// File: rtl/rwf_pkg.sv
// Shared constants and types for the banked windowed register file.
// Assumes a 7-bit specifier and register groups of sixteen entries.
package rwf_pkg;
    localparam int SPEC_W = 7;
    localparam int GRP    = 16;

    typedef enum logic [1:0] {
        LOC_STAT = 2'd0,
        LOC_WIN  = 2'd1,
        LOC_SCR  = 2'd2,
        LOC_RSV  = 2'd3
    } loc_kind_e;
endpackage

// File: rtl/rwf_decode.sv
// Specifier decoder: maps a 7-bit register specifier to a storage kind and an
// index. For window registers the index is the offset inside one bank: the
// base incoming group sits at 0..15, and frame f holds its local group at
// 16+32f and its outgoing group 16 above that.
// Assumes NFRAME is a power of two (the previous frame wraps modulo NFRAME)
// and NSCR <= 64.
module rwf_decode
    import rwf_pkg::*;
#(
    parameter int NFRAME = 4,
    parameter int NSCR   = 8,
    parameter int FW     = $clog2(NFRAME),
    parameter int OFF_W  = $clog2(GRP + NFRAME * 2 * GRP)
) (
    input  logic [SPEC_W-1:0] spec_i,
    input  logic [FW-1:0]     cwp_i,
    input  logic              at_base_i,
    output loc_kind_e         kind_o,
    output logic [OFF_W-1:0]  idx_o
);
    localparam int FRAME_W = 2 * GRP;

    logic [FW-1:0] prev_fp;
    int            cur_base;
    int            prev_base;
    int            reg_n;

    // Work out the kind and the in-bank index of one specifier
    always_comb begin
        prev_fp   = cwp_i - 1'b1;
        cur_base  = GRP + int'(cwp_i) * FRAME_W;
        prev_base = GRP + int'(prev_fp) * FRAME_W;
        reg_n     = int'(spec_i[3:0]);
        kind_o    = LOC_RSV;
        idx_o     = '0;
        if (!spec_i[6]) begin
            case (spec_i[5:4])
                2'd0: begin
                    kind_o = LOC_STAT;
                    idx_o  = OFF_W'(reg_n);
                end
                2'd1: begin
                    kind_o = LOC_WIN;
                    idx_o  = at_base_i ? OFF_W'(reg_n)
                                       : OFF_W'(prev_base + GRP + reg_n);
                end
                2'd2: begin
                    kind_o = LOC_WIN;
                    idx_o  = OFF_W'(cur_base + reg_n);
                end
                default: begin
                    kind_o = LOC_WIN;
                    idx_o  = OFF_W'(cur_base + GRP + reg_n);
                end
            endcase
        end else if (int'(spec_i[5:0]) < NSCR) begin
            kind_o = LOC_SCR;
            idx_o  = OFF_W'(spec_i[5:0]);
        end
    end
endmodule

// File: rtl/rwf_window_ctl.sv
// Window controller: keeps a window pointer and a frame depth for every bank
// and moves only the active bank's pair on call or return. A call at the
// deepest frame, or a return at the base frame, is refused and reported with
// a one-cycle registered flag. A simultaneous call and return does nothing.
// Assumes NFRAME is a power of two and at least 2.
module rwf_window_ctl #(
    parameter int NBANK  = 4,
    parameter int NFRAME = 4,
    parameter int BW     = $clog2(NBANK),
    parameter int FW     = $clog2(NFRAME)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [BW-1:0] bank_i,
    input  logic          call_i,
    input  logic          ret_i,
    output logic [FW-1:0] cwp_o,
    output logic          at_base_o,
    output logic          ovf_o,
    output logic          unf_o
);
    localparam logic [FW-1:0] DEPTH_MAX = FW'(NFRAME - 1);

    logic [FW-1:0] cwp_q   [NBANK];
    logic [FW-1:0] depth_q [NBANK];
    logic          do_call;
    logic          do_ret;
    logic [FW-1:0] depth_cur;

    // Select the active bank's pointer and classify the request
    always_comb begin
        cwp_o     = cwp_q[bank_i];
        depth_cur = depth_q[bank_i];
        at_base_o = (depth_cur == '0);
        do_call   = call_i && !ret_i;
        do_ret    = ret_i && !call_i;
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        // Advance or retreat this bank's window when it is the active one
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cwp_q[b]   <= '0;
                depth_q[b] <= '0;
            end else if (bank_i == BW'(b)) begin
                if (do_call && depth_q[b] != DEPTH_MAX) begin
                    cwp_q[b]   <= cwp_q[b] + 1'b1;
                    depth_q[b] <= depth_q[b] + 1'b1;
                end else if (do_ret && depth_q[b] != '0) begin
                    cwp_q[b]   <= cwp_q[b] - 1'b1;
                    depth_q[b] <= depth_q[b] - 1'b1;
                end
            end
        end

        // R3
        depth_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bank_i == BW'(b) && call_i && !ret_i && depth_q[b] != DEPTH_MAX)
            |=> (depth_q[b] == $past(depth_q[b]) + 1'b1));

        // R6
        idle_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bank_i != BW'(b)) |=> ($stable(depth_q[b]) && $stable(cwp_q[b])));
    end

    // Register the refusal flags for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_o <= 1'b0;
            unf_o <= 1'b0;
        end else begin
            ovf_o <= do_call && (depth_cur == DEPTH_MAX);
            unf_o <= do_ret && (depth_cur == '0);
        end
    end

    // R3
    overflow_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> $past(call_i && !ret_i));

    // R4
    underflow_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unf_o |-> $past(ret_i && !call_i));

    // R5
    no_dual_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(call_i && ret_i) |-> (!ovf_o && !unf_o));
endmodule

// File: rtl/rwf_storage.sv
// Register storage: static registers, scratchpad registers and the banked
// window stack, with one write port and two combinational read ports that
// forward a same-cycle write. Contents have no reset. Unprivileged
// scratchpad writes and all reserved writes are dropped here; the matching
// reads return zero.
module rwf_storage
    import rwf_pkg::*;
#(
    parameter int DW     = 32,
    parameter int NBANK  = 4,
    parameter int NFRAME = 4,
    parameter int NSCR   = 8,
    parameter int BW     = $clog2(NBANK),
    parameter int OFF_W  = $clog2(GRP + NFRAME * 2 * GRP)
) (
    input  logic             clk,
    input  logic             priv_i,
    input  logic [BW-1:0]    bank_i,
    input  logic             wr_en_i,
    input  loc_kind_e        wr_kind_i,
    input  logic [OFF_W-1:0] wr_idx_i,
    input  logic [DW-1:0]    wr_data_i,
    input  loc_kind_e        rd_kind_i [2],
    input  logic [OFF_W-1:0] rd_idx_i  [2],
    output logic [DW-1:0]    rd_data_o [2]
);
    localparam int BANK_WORDS = GRP + NFRAME * 2 * GRP;
    localparam int STK_WORDS  = NBANK * BANK_WORDS;
    localparam int SK_W       = $clog2(STK_WORDS);
    localparam int SC_W       = $clog2(NSCR);

    logic [DW-1:0] stat_mem [GRP];
    logic [DW-1:0] scr_mem  [NSCR];
    logic [DW-1:0] stk_mem  [STK_WORDS];

    logic            wr_ok;
    logic [SK_W-1:0] wr_addr;

    // Decide whether the write is allowed and form its stack address
    always_comb begin
        wr_ok   = wr_en_i && (wr_kind_i != LOC_RSV) &&
                  !(wr_kind_i == LOC_SCR && !priv_i);
        wr_addr = SK_W'(int'(bank_i) * BANK_WORDS + int'(wr_idx_i));
    end

    // Commit the write into the array its kind selects
    always_ff @(posedge clk) begin
        if (wr_ok) begin
            case (wr_kind_i)
                LOC_STAT: stat_mem[wr_idx_i[3:0]]    <= wr_data_i;
                LOC_SCR:  scr_mem[wr_idx_i[SC_W-1:0]] <= wr_data_i;
                LOC_WIN:  stk_mem[wr_addr]           <= wr_data_i;
                default:  ;
            endcase
        end
    end

    for (genvar p = 0; p < 2; p++) begin : g_rd
        logic [SK_W-1:0] rd_addr;
        logic [DW-1:0]   raw;

        // Fetch the stored word, then forward a write to the same place
        always_comb begin
            rd_addr = SK_W'(int'(bank_i) * BANK_WORDS + int'(rd_idx_i[p]));
            case (rd_kind_i[p])
                LOC_STAT: raw = stat_mem[rd_idx_i[p][3:0]];
                LOC_SCR:  raw = priv_i ? scr_mem[rd_idx_i[p][SC_W-1:0]] : '0;
                LOC_WIN:  raw = stk_mem[rd_addr];
                default:  raw = '0;
            endcase
            if (wr_ok && wr_kind_i == rd_kind_i[p] && wr_idx_i == rd_idx_i[p])
                rd_data_o[p] = wr_data_i;
            else
                rd_data_o[p] = raw;
        end
    end
endmodule

// File: rtl/rwf_banked_regfile.sv
// Top of the banked windowed register file. Holds the selected process bank,
// picks the kernel bank while privileged, decodes the three specifiers
// against the active window and raises the privilege-fault flag.
// Assumes the kernel bank is the highest bank and that process code never
// selects it through bank_sel_i.
module rwf_banked_regfile
    import rwf_pkg::*;
#(
    parameter int DW     = 32,
    parameter int NBANK  = 4,
    parameter int NFRAME = 4,
    parameter int NSCR   = 8,
    parameter int BW     = $clog2(NBANK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kernel_i,
    input  logic [BW-1:0]     bank_sel_i,
    input  logic              call_i,
    input  logic              ret_i,
    input  logic [SPEC_W-1:0] rd_a_spec_i,
    output logic [DW-1:0]     rd_a_data_o,
    input  logic [SPEC_W-1:0] rd_b_spec_i,
    output logic [DW-1:0]     rd_b_data_o,
    input  logic              wr_en_i,
    input  logic [SPEC_W-1:0] wr_spec_i,
    input  logic [DW-1:0]     wr_data_i,
    output logic              overflow_o,
    output logic              underflow_o,
    output logic              priv_fault_o
);
    localparam int            FW    = $clog2(NFRAME);
    localparam int            OFF_W = $clog2(GRP + NFRAME * 2 * GRP);
    localparam logic [BW-1:0] KBANK = BW'(NBANK - 1);

    logic [BW-1:0]     cur_bank_q;
    logic [BW-1:0]     eff_bank;
    logic [FW-1:0]     cwp;
    logic              at_base;
    logic [SPEC_W-1:0] spec   [3];
    loc_kind_e         kind   [3];
    logic [OFF_W-1:0]  idx    [3];
    loc_kind_e         rd_kind [2];
    logic [OFF_W-1:0]  rd_idx  [2];
    logic [DW-1:0]     rd_data [2];

    // Take up a new process bank at the edge, refusing the kernel bank
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_bank_q <= '0;
        else if (bank_sel_i != KBANK)
            cur_bank_q <= bank_sel_i;
    end

    // Choose the active bank and gather the specifiers for decoding
    always_comb begin
        eff_bank   = kernel_i ? KBANK : cur_bank_q;
        spec[0]    = rd_a_spec_i;
        spec[1]    = rd_b_spec_i;
        spec[2]    = wr_spec_i;
        rd_kind[0] = kind[0];
        rd_kind[1] = kind[1];
        rd_idx[0]  = idx[0];
        rd_idx[1]  = idx[1];
        rd_a_data_o = rd_data[0];
        rd_b_data_o = rd_data[1];
    end

    rwf_window_ctl #(
        .NBANK (NBANK),
        .NFRAME(NFRAME)
    ) win_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bank_i   (eff_bank),
        .call_i   (call_i),
        .ret_i    (ret_i),
        .cwp_o    (cwp),
        .at_base_o(at_base),
        .ovf_o    (overflow_o),
        .unf_o    (underflow_o)
    );

    for (genvar s = 0; s < 3; s++) begin : g_dec
        rwf_decode #(
            .NFRAME(NFRAME),
            .NSCR  (NSCR)
        ) dec_i (
            .spec_i   (spec[s]),
            .cwp_i    (cwp),
            .at_base_i(at_base),
            .kind_o   (kind[s]),
            .idx_o    (idx[s])
        );
    end

    rwf_storage #(
        .DW    (DW),
        .NBANK (NBANK),
        .NFRAME(NFRAME),
        .NSCR  (NSCR)
    ) mem_i (
        .clk      (clk),
        .priv_i   (kernel_i),
        .bank_i   (eff_bank),
        .wr_en_i  (wr_en_i),
        .wr_kind_i(kind[2]),
        .wr_idx_i (idx[2]),
        .wr_data_i(wr_data_i),
        .rd_kind_i(rd_kind),
        .rd_idx_i (rd_idx),
        .rd_data_o(rd_data)
    );

    // Flag any unprivileged scratchpad touch in the following cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            priv_fault_o <= 1'b0;
        else
            priv_fault_o <= !kernel_i &&
                            ((wr_en_i && kind[2] == LOC_SCR) ||
                             kind[0] == LOC_SCR || kind[1] == LOC_SCR);
    end

    // R7
    kernel_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_bank_q != KBANK);

    // R8
    fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        priv_fault_o |-> $past(!kernel_i));

    // R8
    scr_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!kernel_i && kind[0] == LOC_SCR) |-> (rd_a_data_o == '0));

    // R9
    rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind[0] == LOC_RSV) |-> (rd_a_data_o == '0));
endmodule

// File: tb/rwf_banked_regfile_tb.sv
// Bench for the banked windowed register file: a vector table walked by one
// loop, then directed tests for reset, flags, banks, privilege and bypass.
module rwf_banked_regfile_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        kernel_i = 1'b0;
    logic [1:0]  bank_sel_i = 2'd0;
    logic        call_i = 1'b0;
    logic        ret_i = 1'b0;
    logic [6:0]  rd_a_spec_i = 7'd0;
    logic [31:0] rd_a_data_o;
    logic [6:0]  rd_b_spec_i = 7'd0;
    logic [31:0] rd_b_data_o;
    logic        wr_en_i = 1'b0;
    logic [6:0]  wr_spec_i = 7'd0;
    logic [31:0] wr_data_i = 32'd0;
    logic        overflow_o;
    logic        underflow_o;
    logic        priv_fault_o;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rwf_banked_regfile dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .kernel_i    (kernel_i),
        .bank_sel_i  (bank_sel_i),
        .call_i      (call_i),
        .ret_i       (ret_i),
        .rd_a_spec_i (rd_a_spec_i),
        .rd_a_data_o (rd_a_data_o),
        .rd_b_spec_i (rd_b_spec_i),
        .rd_b_data_o (rd_b_data_o),
        .wr_en_i     (wr_en_i),
        .wr_spec_i   (wr_spec_i),
        .wr_data_i   (wr_data_i),
        .overflow_o  (overflow_o),
        .underflow_o (underflow_o),
        .priv_fault_o(priv_fault_o)
    );

    // Vector: {req[3:0], op[1:0], spec[6:0], data[31:0]}
    // op 0 write, 1 read and compare, 2 call, 3 return
    localparam int NVEC = 13;
    localparam logic [44:0] VEC [NVEC] = '{
        {4'd1, 2'd0, 7'd3,  32'hA1A1_0003},
        {4'd2, 2'd0, 7'd40, 32'h4C00_0040},
        {4'd2, 2'd0, 7'd50, 32'h0E00_0050},
        {4'd2, 2'd2, 7'd0,  32'h0},
        {4'd2, 2'd1, 7'd18, 32'h0E00_0050},
        {4'd1, 2'd1, 7'd3,  32'hA1A1_0003},
        {4'd2, 2'd0, 7'd40, 32'h4C11_0040},
        {4'd2, 2'd1, 7'd40, 32'h4C11_0040},
        {4'd2, 2'd3, 7'd0,  32'h0},
        {4'd2, 2'd1, 7'd40, 32'h4C00_0040},
        {4'd2, 2'd1, 7'd50, 32'h0E00_0050},
        {4'd2, 2'd0, 7'd20, 32'h1A00_0020},
        {4'd2, 2'd1, 7'd20, 32'h1A00_0020}
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [6:0] s, input logic [31:0] d);
        wr_en_i   = 1'b1;
        wr_spec_i = s;
        wr_data_i = d;
        tick();
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [6:0] s, input logic [31:0] exp, input string tag);
        rd_a_spec_i = s;
        #1;
        chk(tag, rd_a_data_o, exp);
        rd_a_spec_i = 7'd0;
    endtask

    task automatic do_call();
        call_i = 1'b1;
        tick();
        call_i = 1'b0;
    endtask

    task automatic do_ret();
        ret_i = 1'b1;
        tick();
        ret_i = 1'b0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    // Watchdog: a hung run counts as one failed check
    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;

        // R11: flags clear after reset, bank 0 window at base
        chk("R11 overflow after reset", {31'd0, overflow_o}, 32'd0);
        chk("R11 underflow after reset", {31'd0, underflow_o}, 32'd0);
        chk("R11 priv_fault after reset", {31'd0, priv_fault_o}, 32'd0);
        do_ret();
        chk("R11 base frame after reset", {31'd0, underflow_o}, 32'd1);
        tick();

        // R1 R2: vector table
        for (int i = 0; i < NVEC; i++) begin
            logic [3:0]  req;
            logic [1:0]  op;
            logic [6:0]  sp;
            logic [31:0] dv;
            {req, op, sp, dv} = VEC[i];
            case (op)
                2'd0: wr(sp, dv);
                2'd1: rd(sp, dv, $sformatf("R%0d table vector %0d", req, i));
                2'd2: begin
                    do_call();
                    chk($sformatf("R%0d table call %0d", req, i), {31'd0, overflow_o}, 32'd0);
                end
                default: begin
                    do_ret();
                    chk($sformatf("R%0d table return %0d", req, i), {31'd0, underflow_o}, 32'd0);
                end
            endcase
        end

        // R3: fourth call overflows and leaves the window alone
        do_call();
        do_call();
        do_call();
        chk("R3 no overflow at depth 3", {31'd0, overflow_o}, 32'd0);
        wr(7'd33, 32'h3333_0033);
        do_call();
        chk("R3 overflow pulse", {31'd0, overflow_o}, 32'd1);
        rd(7'd33, 32'h3333_0033, "R3 window unchanged after overflow");
        tick();
        chk("R3 overflow one cycle", {31'd0, overflow_o}, 32'd0);
        do_ret();
        do_ret();
        do_ret();
        chk("R3 returns after overflow", {31'd0, underflow_o}, 32'd0);
        rd(7'd40, 32'h4C00_0040, "R3 base local restored");

        // R4: return at base
        do_ret();
        chk("R4 underflow pulse", {31'd0, underflow_o}, 32'd1);
        rd(7'd40, 32'h4C00_0040, "R4 window unchanged after underflow");
        tick();
        chk("R4 underflow one cycle", {31'd0, underflow_o}, 32'd0);

        // R5: call and return together
        call_i = 1'b1;
        ret_i  = 1'b1;
        tick();
        call_i = 1'b0;
        ret_i  = 1'b0;
        chk("R5 no overflow", {31'd0, overflow_o}, 32'd0);
        chk("R5 no underflow", {31'd0, underflow_o}, 32'd0);
        do_ret();
        chk("R5 still at base", {31'd0, underflow_o}, 32'd1);

        // R12: write and call in the same cycle
        wr_en_i   = 1'b1;
        wr_spec_i = 7'd49;
        wr_data_i = 32'h1200_0049;
        call_i    = 1'b1;
        tick();
        wr_en_i = 1'b0;
        call_i  = 1'b0;
        rd(7'd17, 32'h1200_0049, "R12 write landed in caller outgoing");
        do_ret();
        rd(7'd49, 32'h1200_0049, "R12 caller outgoing after return");

        // R6: bank select takes effect at the next edge; banks independent
        bank_sel_i = 2'd1;
        rd(7'd40, 32'h4C00_0040, "R6 bank change not yet active");
        tick();
        wr(7'd40, 32'hB100_0040);
        do_call();
        bank_sel_i = 2'd0;
        tick();
        rd(7'd40, 32'h4C00_0040, "R6 bank 0 local kept");
        do_ret();
        chk("R6 bank 0 depth independent", {31'd0, underflow_o}, 32'd1);
        bank_sel_i = 2'd1;
        tick();
        do_ret();
        chk("R6 bank 1 depth kept", {31'd0, underflow_o}, 32'd0);
        rd(7'd40, 32'hB100_0040, "R6 bank 1 local kept");
        bank_sel_i = 2'd0;
        tick();

        // R7: kernel bank
        kernel_i = 1'b1;
        wr(7'd40, 32'hCE00_0040);
        kernel_i = 1'b0;
        rd(7'd40, 32'h4C00_0040, "R7 process bank untouched by kernel");
        kernel_i = 1'b1;
        rd(7'd40, 32'hCE00_0040, "R7 kernel bank immediate");
        rd(7'd3, 32'hA1A1_0003, "R1 static visible in kernel");
        kernel_i   = 1'b0;
        bank_sel_i = 2'd3;
        tick();
        tick();
        rd(7'd40, 32'h4C00_0040, "R7 kernel bank select ignored");
        bank_sel_i = 2'd0;
        tick();

        // R8: scratchpad privilege
        kernel_i = 1'b1;
        wr(7'd64, 32'h5C00_0064);
        kernel_i = 1'b0;
        wr(7'd64, 32'hDEAD_0064);
        chk("R8 fault on unprivileged write", {31'd0, priv_fault_o}, 32'd1);
        kernel_i = 1'b1;
        rd(7'd64, 32'h5C00_0064, "R8 unprivileged write dropped");
        rd_a_spec_i = 7'd71;
        tick();
        rd_a_spec_i = 7'd0;
        chk("R8 no fault when privileged", {31'd0, priv_fault_o}, 32'd0);
        kernel_i = 1'b0;
        rd(7'd64, 32'h0, "R8 unprivileged read zero");
        tick();

        // R9: reserved specifiers
        wr(7'd100, 32'hFFFF_0100);
        rd(7'd100, 32'h0, "R9 reserved read zero");
        rd(7'd3, 32'hA1A1_0003, "R9 static unaffected by reserved write");
        rd(7'd64 + 7'd8, 32'h0, "R9 first reserved above scratchpad");

        // R10: same-cycle bypass, static and window
        wr_en_i     = 1'b1;
        wr_spec_i   = 7'd5;
        wr_data_i   = 32'hB5B5_0005;
        rd_b_spec_i = 7'd5;
        #1;
        chk("R10 static bypass", rd_b_data_o, 32'hB5B5_0005);
        tick();
        wr_spec_i   = 7'd34;
        wr_data_i   = 32'hB3B3_0034;
        rd_b_spec_i = 7'd34;
        #1;
        chk("R10 window bypass", rd_b_data_o, 32'hB3B3_0034);
        tick();
        wr_en_i     = 1'b0;
        rd_b_spec_i = 7'd0;
        rd(7'd5, 32'hB5B5_0005, "R10 static stored");
        rd(7'd34, 32'hB3B3_0034, "R10 window stored");

        tick();
        summary();
        $finish;
    end
endmodule